// File: doc/BRIEF.md
# Supply Fault Reset Generator

This block drives an active-low system reset from a set of supply-good comparator flags, a manual reset pin and a set of over-current flags. The reset is held while any supply is below its threshold, while the manual reset is held low, or for at least one cycle after any over-current flag is seen. Once every cause is gone, the reset is kept asserted for a stretch time chosen by a 2-bit code, and only then is it released.

All inputs are synchronous digital results except the manual reset pin. That pin is passed through a two-flop synchroniser and a debounce filter before it is used. The stretch counter restarts whenever a cause comes back, so the reset is always released a full stretch after the last cause ends. Out of the power-on reset the output starts asserted and runs one full stretch.

Top module: `supply_reset_gen`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0. After `por_n` goes high with no cause present, `sys_rst_n` goes to 1 on the L-th rising clock edge, where L is the selected stretch length.
- R2: If any bit of `supply_good` is 0 at a rising edge, `sys_rst_n` is 0 after that edge.
- R3: `man_rst_n` passes through a 2-stage synchroniser. It counts as active only after 4 consecutive synchronised low samples and as inactive only after 4 consecutive high samples. A low pulse shorter than 4 cycles leaves `sys_rst_n` unchanged.
- R4: Any bit of `oc_flag` that is 1 at a rising edge is captured for one cycle. It asserts `sys_rst_n` = 0 two edges later, and it starts a full stretch even when it is a single-cycle pulse.
- R5: Once all causes are absent, `sys_rst_n` goes to 1 on the L-th consecutive rising edge without a cause. It then stays 1 until a cause appears.
- R6: `stretch_sel` picks L: 0 gives STRETCH0 (default 16), 1 gives STRETCH1 (32), 2 gives STRETCH2 (64), 3 gives STRETCH3 (128). The code is read on every edge of the stretch.
- R7: A cause that comes back during a stretch restarts the count from zero. The release then comes L cause-free edges after that cause ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_good | input | N_SUPPLY | 1 = supply above threshold, per monitored rail |
| man_rst_n | input | 1 | Manual reset pin, active low, asynchronous |
| oc_flag | input | N_OC | 1 = over-current seen on that channel |
| stretch_sel | input | 2 | Stretch-length code |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The output is first measured after a power-on release with no cause, which isolates the stretch length for each code. Each cause is then applied on its own:
- A supply dip separates the immediate assertion from the counted release.
- A single-cycle over-current pulse shows that the capture stage stretches a pulse that would otherwise be lost.
- A 3-cycle manual low pulse against a 10-cycle one tells the debounce apart from a plain synchroniser.

A dip that comes back mid-stretch checks the restart rather than a resumed count. Random mixes of all causes and code changes, compared against a cycle model, cover overlapping causes.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    TM_HOLD     = 2'd0,
    TM_STRETCH  = 2'd1,
    TM_RELEASED = 2'd2
  } tmr_state_t;

  function automatic int unsigned pick_stretch(input logic [1:0] sel,
                                               input int unsigned s0,
                                               input int unsigned s1,
                                               input int unsigned s2,
                                               input int unsigned s3);
    case (sel)
      2'd0:    return s0;
      2'd1:    return s1;
      2'd2:    return s2;
      default: return s3;
    endcase
  endfunction

  function automatic int unsigned max_of4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sfr_mr_filter.sv
module sfr_mr_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEBOUNCE    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic man_rst_n,
  output logic mr_active
);
  localparam int unsigned HW = (DEBOUNCE > 1) ? DEBOUNCE - 1 : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   mr_req;
  logic [HW-1:0]          hist_q;
  logic [DEBOUNCE-1:0]    window;
  logic                   all_low_req;
  logic                   all_high_req;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ~man_rst_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign mr_req = sync_q[SYNC_STAGES-1];

  generate
    if (DEBOUNCE > 1) begin : g_win
      assign window = {hist_q[DEBOUNCE-2:0], mr_req};
    end else begin : g_win1
      assign window = mr_req;
    end
  endgenerate

  assign all_low_req  = &window;
  assign all_high_req = ~|window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      mr_active <= 1'b0;
    end else begin
      if (DEBOUNCE > 1) hist_q <= window[HW-1:0];
      if (all_low_req)       mr_active <= 1'b1;
      else if (all_high_req) mr_active <= 1'b0;
    end
  end

  // R3: the filtered request only turns on after a run of asserted samples
  a_r3_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_active) |-> ($past(mr_req) && $past(window[DEBOUNCE-1])));
  // R3: and only turns off after a run of released samples
  a_r3_fall_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mr_active) |-> (!$past(mr_req) && !$past(window[DEBOUNCE-1])));

endmodule

// File: rtl/sfr_oc_capture.sv
module sfr_oc_capture #(
  parameter int unsigned N_OC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_OC-1:0] oc_flag,
  output logic            oc_hit
);
  logic [N_OC-1:0] lane_q;

  genvar g;
  generate
    for (g = 0; g < N_OC; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q[g] <= 1'b0;
        else        lane_q[g] <= oc_flag[g];
      end
    end
  endgenerate

  assign oc_hit = |lane_q;

  // R4: any flag seen at an edge is held as a hit for the following cycle
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_flag) |=> oc_hit);
  a_r4_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !(|oc_flag) |=> !oc_hit);

endmodule

// File: rtl/sfr_stretch_timer.sv
module sfr_stretch_timer
  import sfr_pkg::*;
#(
  parameter int unsigned STRETCH0 = 16,
  parameter int unsigned STRETCH1 = 32,
  parameter int unsigned STRETCH2 = 64,
  parameter int unsigned STRETCH3 = 128,
  parameter int unsigned CNT_W    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cause,
  input  logic [1:0] stretch_sel,
  output logic       rst_out_n
);
  tmr_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             release_now;
  logic             counting;

  assign last_cnt = CNT_W'(pick_stretch(stretch_sel, STRETCH0, STRETCH1,
                                        STRETCH2, STRETCH3) - 1);
  assign counting    = !cause && (state_q != TM_RELEASED);
  assign release_now = counting && (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TM_HOLD;
      cnt_q   <= '0;
    end else if (cause) begin
      state_q <= TM_HOLD;
      cnt_q   <= '0;
    end else if (release_now) begin
      state_q <= TM_RELEASED;
      cnt_q   <= '0;
    end else if (counting) begin
      state_q <= TM_STRETCH;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign rst_out_n = (state_q == TM_RELEASED);

  // R2: a cause at an edge leaves the reset asserted after it
  a_r2_cause_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> !rst_out_n);
  // R5: once released, the output stays high while no cause appears
  a_r5_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !cause) |=> rst_out_n);
  // R5: release happens only on a cause-free edge
  a_r5_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> !$past(cause));
  // R7: while stretching without a cause, the count advances by one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !release_now) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: a cause clears the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (cnt_q == '0));

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import sfr_pkg::*;
#(
  parameter int unsigned N_SUPPLY    = 4,
  parameter int unsigned N_OC        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEBOUNCE    = 4,
  parameter int unsigned STRETCH0    = 16,
  parameter int unsigned STRETCH1    = 32,
  parameter int unsigned STRETCH2    = 64,
  parameter int unsigned STRETCH3    = 128
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic [N_SUPPLY-1:0] supply_good,
  input  logic                man_rst_n,
  input  logic [N_OC-1:0]     oc_flag,
  input  logic [1:0]          stretch_sel,
  output logic                sys_rst_n
);
  localparam int unsigned MAX_STRETCH =
    max_of4(STRETCH0, STRETCH1, STRETCH2, STRETCH3);
  localparam int unsigned CNT_W = $clog2(MAX_STRETCH) + 1;

  logic [N_SUPPLY-1:0] rail_fault;
  logic                supply_fault;
  logic                mr_active;
  logic                oc_hit;
  logic                cause;

  genvar g;
  generate
    for (g = 0; g < N_SUPPLY; g++) begin : g_rail
      assign rail_fault[g] = ~supply_good[g];
    end
  endgenerate

  assign supply_fault = |rail_fault;

  sfr_mr_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEBOUNCE   (DEBOUNCE)
  ) u_mr_filter (
    .clk      (clk),
    .rst_n    (por_n),
    .man_rst_n(man_rst_n),
    .mr_active(mr_active)
  );

  sfr_oc_capture #(
    .N_OC(N_OC)
  ) u_oc_capture (
    .clk    (clk),
    .rst_n  (por_n),
    .oc_flag(oc_flag),
    .oc_hit (oc_hit)
  );

  assign cause = supply_fault | mr_active | oc_hit;

  sfr_stretch_timer #(
    .STRETCH0(STRETCH0),
    .STRETCH1(STRETCH1),
    .STRETCH2(STRETCH2),
    .STRETCH3(STRETCH3),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (por_n),
    .cause      (cause),
    .stretch_sel(stretch_sel),
    .rst_out_n  (sys_rst_n)
  );

  // R1: the reset output is asserted while power-on reset is held
  always_comb begin
    if (!por_n) a_r1_por_asserted: assert (!sys_rst_n);
  end
  // R2: a low supply flag asserts the reset after the edge
  a_r2_supply: assert property (@(posedge clk) disable iff (!por_n)
    !(&supply_good) |=> !sys_rst_n);
  // R4: an over-current flag asserts the reset two edges later
  a_r4_oc_reset: assert property (@(posedge clk) disable iff (!por_n)
    (|oc_flag) |=> ##1 !sys_rst_n);

endmodule

// File: tb/test_supply_reset_gen.sv
`timescale 1ns/1ps
module test_supply_reset_gen;
  localparam int NS = 4;
  localparam int NO = 4;

  logic          clk = 1'b0;
  logic          por_n;
  logic [NS-1:0] supply_good;
  logic          man_rst_n;
  logic [NO-1:0] oc_flag;
  logic [1:0]    stretch_sel;
  logic          sys_rst_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // bench model state
  logic       m_s1, m_s2, m_act, m_oc, m_out;
  logic [2:0] m_hist;
  int         m_cnt;

  always #2 clk = ~clk;

  supply_reset_gen i_supply_reset_gen (
    .clk(clk), .por_n(por_n), .supply_good(supply_good),
    .man_rst_n(man_rst_n), .oc_flag(oc_flag),
    .stretch_sel(stretch_sel), .sys_rst_n(sys_rst_n)
  );

  function automatic int len_of(input logic [1:0] s);
    return 16 << s;  // R6: 16, 32, 64, 128
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sys_rst_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: value=%0d expected %0d", req, act, exp);
    end
  endtask

  // model of the next rising edge, using inputs as driven now
  task automatic model_step();
    logic f;
    logic [3:0] w;
    if (!por_n) begin
      m_s1 = 0; m_s2 = 0; m_hist = 0; m_act = 0; m_oc = 0; m_cnt = 0; m_out = 0;
    end else begin
      f = !(&supply_good) || m_act || m_oc;          // R2, R3, R4
      w = {m_hist, m_s2};
      if (&w) m_act = 1; else if (w == 0) m_act = 0; // R3 debounce
      m_hist = w[2:0];
      m_s2 = m_s1; m_s1 = ~man_rst_n;
      m_oc = |oc_flag;                               // R4 capture
      if (f) begin m_cnt = 0; m_out = 0; end         // R7 restart
      else if (!m_out) begin
        if (m_cnt >= len_of(stretch_sel) - 1) begin m_out = 1; m_cnt = 0; end // R5
        else m_cnt++;
      end
    end
  endtask

  task automatic tick(input string req);
    model_step();
    @(negedge clk);
    check(sys_rst_n, m_out, req);
  endtask

  // count edges until release, with model checks each cycle
  task automatic edges_to_release(output int n, input string req);
    n = 0;
    do begin
      tick(req);
      n++;
    end while (!sys_rst_n && n < 400);
  endtask

  task automatic idle();
    supply_good = '1; man_rst_n = 1; oc_flag = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    idle(); stretch_sel = 2'd0; por_n = 0;
    model_step();
    repeat (3) @(negedge clk);
    check(sys_rst_n, 1'b0, "R1 reset state");

    // R1: full stretch out of power-on reset
    por_n = 1;
    edges_to_release(n, "R1");
    check_int(n, 16, "R1 power-on stretch");

    // R2: supply dip
    supply_good = 4'b1011;
    tick("R2");
    check(sys_rst_n, 1'b0, "R2 supply dip asserts");
    idle();
    edges_to_release(n, "R5");
    check_int(n, 16, "R5 release after supply restore");

    // R6: each code
    for (int s = 1; s < 4; s++) begin
      stretch_sel = 2'(s);
      supply_good = 4'b0111;
      tick("R6");
      idle();
      edges_to_release(n, "R6");
      check_int(n, len_of(2'(s)), "R6 stretch per code");
    end
    stretch_sel = 2'd0;

    // R4: single-cycle over-current pulse
    oc_flag = 4'b0100;
    tick("R4");
    oc_flag = '0;
    tick("R4");
    check(sys_rst_n, 1'b0, "R4 oc pulse asserts");
    edges_to_release(n, "R4");
    check_int(n, 16, "R4 full stretch after oc pulse");

    // R3: short manual pulse ignored
    man_rst_n = 0;
    repeat (3) tick("R3");
    man_rst_n = 1;
    for (int i = 0; i < 12; i++) begin
      tick("R3");
      check(sys_rst_n, 1'b1, "R3 short manual pulse ignored");
    end

    // R3: long manual pulse asserts
    man_rst_n = 0;
    repeat (10) tick("R3");
    check(sys_rst_n, 1'b0, "R3 held manual reset asserts");
    man_rst_n = 1;
    edges_to_release(n, "R3");
    check(sys_rst_n, 1'b1, "R3 release after manual reset");

    // R7: cause returns mid-stretch
    supply_good = 4'b1110;
    tick("R7");
    idle();
    repeat (8) tick("R7");
    supply_good = 4'b1101;
    tick("R7");
    idle();
    edges_to_release(n, "R7");
    check_int(n, 16, "R7 stretch restarts");

    // random mix against the model
    for (int i = 0; i < 6000; i++) begin
      supply_good = '1;
      if ($urandom % 40 == 0) supply_good = 4'($urandom);
      oc_flag = ($urandom % 60 == 0) ? 4'($urandom) : '0;
      if ($urandom % 25 == 0) man_rst_n = ~man_rst_n;
      if ($urandom % 300 == 0) stretch_sel = 2'($urandom % 2);
      tick("R5 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule